// File: doc/BRIEF.md
# Per-Drive Recording Mode Configuration Register

This block keeps the recording-mode setting of four logical floppy drives and turns it into three per-access controls for the drive now selected: a perpendicular-mode flag, the length of the gap written between a sector's address field and its data field, and a flag that turns off write precompensation. A host writes one configuration byte through a single-cycle strobe. The configuration can be rewritten at any moment, including between commands.

The byte has three parts. The first is a four-bit per-drive mode field. The second is a two-bit global override field; any nonzero value in it makes every drive perpendicular. The third is an overwrite-enable bit. The per-drive field is loaded only when the overwrite-enable bit in the same byte is set. The override field is loaded on every write.

There are two resets. A synchronous soft reset clears only the override field. The asynchronous hardware reset clears everything, which puts all drives in conventional mode. The outputs are registered and follow the stored state, the drive select and the data-rate code one clock edge later.

Top module: `fdc_perp_cfg`

## Requirements
- R1: With the override field at zero, `perp_mode` equals per-drive bit `wr_data[n]` as last loaded, where n is the value of `drv_sel`. A 1 in that bit means perpendicular and a 0 means conventional.
- R2: The per-drive bits load from `wr_data[3:0]` only when `wr_data[7]` (overwrite enable) is 1 in the same write. When `wr_data[7]` is 0, all four keep their values.
- R3: The override field loads from `wr_data[5:4]` on every write, whatever `wr_data[7]` holds. Any nonzero value forces `perp_mode` to 1 for every drive. `wr_data[6]` has no effect.
- R4: A `soft_rst` pulse clears the override field and leaves the per-drive bits unchanged. If `wr_en` is high in the same cycle, the write is ignored.
- R5: While `rst_n` is low, and without waiting for a clock edge, all stored bits clear and the outputs read `perp_mode`=0, `gap2_len`=22, `precomp_off`=0.
- R6: All outputs are registered. A write, soft reset, `drv_sel` change or `rate_sel` change sampled at one rising edge shows at the outputs right after that same edge. Back-to-back writes each take effect.
- R7: `precomp_off` is 1 exactly when `perp_mode` is 1.
- R8: `gap2_len` is 41 when `perp_mode` is 1 and `rate_sel` is 2 (1 Mbps) or 3 (2 Mbps). Otherwise it is 22. Codes 0 and 1 mean 250 kbps and 500 kbps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| wr_en | input | 1 | Configuration write strobe, one cycle |
| wr_data | input | 8 | Configuration byte |
| drv_sel | input | 2 | Selected logical drive |
| rate_sel | input | 2 | Data-rate code |
| perp_mode | output | 1 | Selected drive runs in perpendicular mode |
| gap2_len | output | 8 | GAP2 length in bytes |
| precomp_off | output | 1 | Write precompensation forced to zero |

## Verification
A per-drive bit that was stored wrongly shows up only when `drv_sel` points at that drive and the override field is zero. For that reason the bench sweeps all four selects after every change of configuration. Each fault becomes visible one edge after the stimulus. A write that escaped the overwrite gate, or a soft reset that also cleared the drive bits, looks correct until a later read with the override at zero, so such a read follows every gate and reset test. A wrong gap selection shows only at the fast rate codes with perpendicular mode in force.

// File: rtl/fdc_perp_pkg.sv
package fdc_perp_pkg;

   // Field positions inside the configuration byte
   localparam int unsigned CFG_DRV_LSB = 0;
   localparam int unsigned CFG_OVR_LSB = 4;
   localparam int unsigned CFG_OVR_W   = 2;
   localparam int unsigned CFG_OW_BIT  = 7;

   // Data-rate codes
   typedef enum logic [1:0] {
      RATE_250K = 2'd0,
      RATE_500K = 2'd1,
      RATE_1M   = 2'd2,
      RATE_2M   = 2'd3
   } rate_e;

   // Rates at which a perpendicular drive needs the long gap
   function automatic logic is_fast_rate(input logic [1:0] code);
      return (code == RATE_1M) || (code == RATE_2M);
   endfunction

endpackage

// File: rtl/fdc_perp_store.sv
module fdc_perp_store #(
   parameter int unsigned NUM_DRV = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DRV_LSB = 0,
   parameter int unsigned OVR_LSB = 4,
   parameter int unsigned OVR_W   = 2,
   parameter int unsigned OW_BIT  = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [NUM_DRV-1:0] drv_q,
   output logic [OVR_W-1:0]   ovr_q,
   output logic [NUM_DRV-1:0] drv_nxt,
   output logic [OVR_W-1:0]   ovr_nxt
);

   if (DRV_LSB + NUM_DRV > DATA_W) begin : g_bad_drv
      $error("drive field does not fit in the configuration byte");
   end
   if (OVR_LSB + OVR_W > DATA_W) begin : g_bad_ovr
      $error("override field does not fit in the configuration byte");
   end
   if (OW_BIT >= DATA_W) begin : g_bad_ow
      $error("overwrite-enable bit lies outside the configuration byte");
   end

   logic wr_ok;
   logic ld_drv;

   assign wr_ok  = wr_en && !soft_rst;
   assign ld_drv = wr_ok && wr_data[OW_BIT];

   // The override field clears on soft reset and loads on every accepted write
   always_comb begin
      if (soft_rst)   ovr_nxt = '0;
      else if (wr_ok) ovr_nxt = wr_data[OVR_LSB +: OVR_W];
      else            ovr_nxt = ovr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovr_q <= '0;
      else        ovr_q <= ovr_nxt;
   end

   // One flop per drive; only the hardware reset clears them
   for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
      assign drv_nxt[d] = ld_drv ? wr_data[DRV_LSB + d] : drv_q[d];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drv_q[d] <= 1'b0;
         else        drv_q[d] <= drv_nxt[d];
      end
   end

endmodule

// File: rtl/fdc_perp_resolve.sv
module fdc_perp_resolve #(
   parameter int unsigned NUM_DRV   = 4,
   parameter int unsigned OVR_W     = 2,
   parameter bit          ONEHOT_MUX = 1'b0,
   localparam int unsigned SEL_W    = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
   input  logic [NUM_DRV-1:0] drv_bits,
   input  logic [OVR_W-1:0]   ovr,
   input  logic [SEL_W-1:0]   drv_sel,
   output logic               perp
);

   if (NUM_DRV < 1) begin : g_bad_num
      $error("at least one drive is needed");
   end

   logic drv_pick;

   if (ONEHOT_MUX) begin : g_onehot
      // Decode the select, then AND-OR: a shallow tree for wide fields
      logic [NUM_DRV-1:0] dec;
      for (genvar d = 0; d < NUM_DRV; d++) begin : g_dec
         assign dec[d] = (drv_sel == SEL_W'(d));
      end
      assign drv_pick = |(dec & drv_bits);
   end else begin : g_index
      // Plain indexed mux; an out-of-range select reads conventional
      always_comb begin
         drv_pick = 1'b0;
         for (int d = 0; d < NUM_DRV; d++) begin
            if (drv_sel == SEL_W'(d)) drv_pick = drv_bits[d];
         end
      end
   end

   // Any nonzero override value wins over the per-drive bits
   assign perp = (|ovr) || drv_pick;

endmodule

// File: rtl/fdc_perp_gap.sv
module fdc_perp_gap #(
   parameter int unsigned GAP_W    = 8,
   parameter int unsigned GAP_STD  = 22,
   parameter int unsigned GAP_PERP = 41
) (
   input  logic             perp,
   input  logic [1:0]       rate_sel,
   output logic [GAP_W-1:0] gap_len,
   output logic             precomp_off
);
   import fdc_perp_pkg::*;

   if (GAP_STD >= (1 << GAP_W) || GAP_PERP >= (1 << GAP_W)) begin : g_bad_gap
      $error("gap length does not fit in GAP_W bits");
   end

   logic long_gap;

   assign long_gap    = perp && is_fast_rate(rate_sel);
   assign gap_len     = long_gap ? GAP_W'(GAP_PERP) : GAP_W'(GAP_STD);
   assign precomp_off = perp;

endmodule

// File: rtl/fdc_perp_cfg.sv
module fdc_perp_cfg #(
   parameter int unsigned NUM_DRV    = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned GAP_W      = 8,
   parameter int unsigned GAP_STD    = 22,
   parameter int unsigned GAP_PERP   = 41,
   parameter bit          ONEHOT_MUX = 1'b0,
   localparam int unsigned SEL_W     = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1,
   localparam int unsigned OVR_W     = fdc_perp_pkg::CFG_OVR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0] drv_sel,
   input  logic [1:0]       rate_sel,
   output logic             perp_mode,
   output logic [GAP_W-1:0] gap2_len,
   output logic             precomp_off
);
   import fdc_perp_pkg::*;

   if (DATA_W < 8) begin : g_bad_data
      $error("configuration byte must be at least 8 bits");
   end

   logic [NUM_DRV-1:0] drv_q;
   logic [NUM_DRV-1:0] drv_nxt;
   logic [OVR_W-1:0]   ovr_q;
   logic [OVR_W-1:0]   ovr_nxt;
   logic               perp_nxt;
   logic [GAP_W-1:0]   gap_nxt;
   logic               pc_nxt;

   fdc_perp_store #(
      .NUM_DRV (NUM_DRV),
      .DATA_W  (DATA_W),
      .DRV_LSB (CFG_DRV_LSB),
      .OVR_LSB (CFG_OVR_LSB),
      .OVR_W   (OVR_W),
      .OW_BIT  (CFG_OW_BIT)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .drv_q    (drv_q),
      .ovr_q    (ovr_q),
      .drv_nxt  (drv_nxt),
      .ovr_nxt  (ovr_nxt)
   );

   // Resolution runs on next state so outputs land on the write edge
   fdc_perp_resolve #(
      .NUM_DRV    (NUM_DRV),
      .OVR_W      (OVR_W),
      .ONEHOT_MUX (ONEHOT_MUX)
   ) u_resolve (
      .drv_bits (drv_nxt),
      .ovr      (ovr_nxt),
      .drv_sel  (drv_sel),
      .perp     (perp_nxt)
   );

   fdc_perp_gap #(
      .GAP_W    (GAP_W),
      .GAP_STD  (GAP_STD),
      .GAP_PERP (GAP_PERP)
   ) u_gap (
      .perp        (perp_nxt),
      .rate_sel    (rate_sel),
      .gap_len     (gap_nxt),
      .precomp_off (pc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perp_mode   <= 1'b0;
         gap2_len    <= GAP_W'(GAP_STD);
         precomp_off <= 1'b0;
      end else begin
         perp_mode   <= perp_nxt;
         gap2_len    <= gap_nxt;
         precomp_off <= pc_nxt;
      end
   end

endmodule

// File: rtl/fdc_perp_cfg_chk.sv
module fdc_perp_cfg_chk #(
   parameter int unsigned NUM_DRV  = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned GAP_W    = 8,
   parameter int unsigned GAP_STD  = 22,
   parameter int unsigned GAP_PERP = 41,
   parameter int unsigned SEL_W    = 2,
   parameter int unsigned OVR_W    = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               soft_rst,
   input logic               wr_en,
   input logic [DATA_W-1:0]  wr_data,
   input logic [SEL_W-1:0]   drv_sel,
   input logic [1:0]         rate_sel,
   input logic [NUM_DRV-1:0] drv_q,
   input logic [OVR_W-1:0]   ovr_q,
   input logic               perp_mode,
   input logic [GAP_W-1:0]   gap2_len,
   input logic               precomp_off
);

   // R2
   ow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[7] && !soft_rst) |=> $stable(drv_q));

   // R4
   soft_keep_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> ($stable(drv_q) && ovr_q == '0));

   // R3
   ovr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !soft_rst) |=> (ovr_q == $past(wr_data[5:4])));

   // R3
   ovr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q != '0) |-> perp_mode);

   // R1
   drv_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q == '0) |-> (perp_mode == drv_q[$past(drv_sel)]));

   // R7
   precomp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      precomp_off == perp_mode);

   // R8
   gap_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !perp_mode |-> (gap2_len == GAP_W'(GAP_STD)));

   // R8
   gap_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      perp_mode |-> (gap2_len == (($past(rate_sel) >= 2'd2) ? GAP_W'(GAP_PERP) : GAP_W'(GAP_STD))));

endmodule

bind fdc_perp_cfg fdc_perp_cfg_chk #(
   .NUM_DRV  (NUM_DRV),
   .DATA_W   (DATA_W),
   .GAP_W    (GAP_W),
   .GAP_STD  (GAP_STD),
   .GAP_PERP (GAP_PERP),
   .SEL_W    (SEL_W),
   .OVR_W    (OVR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .soft_rst    (soft_rst),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .drv_sel     (drv_sel),
   .rate_sel    (rate_sel),
   .drv_q       (drv_q),
   .ovr_q       (ovr_q),
   .perp_mode   (perp_mode),
   .gap2_len    (gap2_len),
   .precomp_off (precomp_off)
);

// File: tb/fdc_perp_cfg_tb.sv
module fdc_perp_cfg_tb;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] drv_sel = 2'd0;
   logic [1:0] rate_sel = 2'd0;
   logic       perp_mode;
   logic [7:0] gap2_len;
   logic       precomp_off;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic       perp;
      logic [7:0] gap;
      logic       pc;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   // Reference state
   logic [3:0] m_drv = 4'h0;
   logic [1:0] m_ovr = 2'b00;

   always #(CLK_P/2) clk = ~clk;

   fdc_perp_cfg u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .drv_sel     (drv_sel),
      .rate_sel    (rate_sel),
      .perp_mode   (perp_mode),
      .gap2_len    (gap2_len),
      .precomp_off (precomp_off)
   );

   task automatic compare(input logic p, input logic [7:0] g, input logic c, input string tag);
      n_chk++;
      if (perp_mode !== p || gap2_len !== g || precomp_off !== c) begin
         n_fail++;
         $display("FAIL %s: got perp=%0b gap=%0d pc=%0b, expected perp=%0b gap=%0d pc=%0b",
                  tag, perp_mode, gap2_len, precomp_off, p, g, c);
      end
   endtask

   // Driver: one cycle of stimulus, expected outputs pushed to the scoreboard
   task automatic step(input logic wr, input logic [7:0] data, input logic srst,
                       input logic [1:0] sel, input logic [1:0] rate, input string tag);
      exp_t e;
      @(negedge clk);
      wr_en = wr; wr_data = data; soft_rst = srst; drv_sel = sel; rate_sel = rate;
      if (srst) m_ovr = 2'b00;
      else if (wr) begin
         if (data[7]) m_drv = data[3:0];
         m_ovr = data[5:4];
      end
      e.perp = (m_ovr != 2'b00) || m_drv[sel];
      e.gap  = (e.perp && rate >= 2'd2) ? 8'd41 : 8'd22;
      e.pc   = e.perp;
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   task automatic sweep(input logic [1:0] rate, input string tag);
      for (int d = 0; d < 4; d++) step(1'b0, 8'h00, 1'b0, 2'(d), rate, tag);
   endtask

   // Monitor
   always @(posedge clk) begin
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         compare(e.perp, e.gap, e.pc, e.tag);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 3000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      // R5: reset state
      #(CLK_P * 2 + 1);
      compare(1'b0, 8'd22, 1'b0, "R5 reset state");
      @(negedge clk); rst_n = 1'b1;

      // R1: per-drive bits, no override
      step(1'b1, 8'h85, 1'b0, 2'd0, 2'd0, "R1 write 0101");
      sweep(2'd0, "R1 sel sweep 0101");
      step(1'b1, 8'h8A, 1'b0, 2'd1, 2'd1, "R1 write 1010");
      sweep(2'd1, "R1 sel sweep 1010");

      // R2: overwrite gate closed
      step(1'b1, 8'h05, 1'b0, 2'd0, 2'd0, "R2 gated write");
      sweep(2'd0, "R2 bits kept");
      // R3: bit 6 has no effect, override loads even with gate closed
      step(1'b1, 8'h4F, 1'b0, 2'd0, 2'd0, "R3 bit6 ignored");
      sweep(2'd0, "R3 bit6 sweep");
      step(1'b1, 8'h10, 1'b0, 2'd0, 2'd0, "R3 override 01 gate closed");
      sweep(2'd0, "R3 override 01 sweep");
      step(1'b1, 8'h20, 1'b0, 2'd2, 2'd0, "R3 override 10");
      step(1'b1, 8'hB0, 1'b0, 2'd3, 2'd0, "R3 override 11 drv clear");
      sweep(2'd3, "R8 override fast rate");

      // R4: soft reset clears override, keeps drive bits (now 0000)
      step(1'b0, 8'h00, 1'b1, 2'd0, 2'd0, "R4 soft reset");
      sweep(2'd0, "R4 override cleared");
      step(1'b1, 8'h8C, 1'b0, 2'd2, 2'd2, "R1 write 1100");
      step(1'b1, 8'h30, 1'b0, 2'd0, 2'd0, "R3 override set");
      step(1'b0, 8'h00, 1'b1, 2'd0, 2'd0, "R4 soft reset keeps drv");
      sweep(2'd3, "R4 drv 1100 kept");
      step(1'b1, 8'hBF, 1'b1, 2'd0, 2'd0, "R4 write blocked by soft reset");
      sweep(2'd0, "R4 blocked write sweep");

      // R8: rate sweep, perpendicular and conventional
      for (int r = 0; r < 4; r++) begin
         step(1'b0, 8'h00, 1'b0, 2'd3, 2'(r), "R8 perp rate");
         step(1'b0, 8'h00, 1'b0, 2'd0, 2'(r), "R8 conv rate");
      end

      // R6: back-to-back writes and select changes each take effect
      step(1'b1, 8'h81, 1'b0, 2'd0, 2'd3, "R6 back-to-back a");
      step(1'b1, 8'h80, 1'b0, 2'd0, 2'd3, "R6 back-to-back b");
      step(1'b1, 8'h8F, 1'b0, 2'd1, 2'd2, "R6 back-to-back c");
      step(1'b0, 8'h00, 1'b0, 2'd1, 2'd1, "R7 R6 rate change");

      // R5: hardware reset mid-run is asynchronous
      wait (exp_q.size() == 0);
      @(negedge clk);
      #(CLK_P/4);
      rst_n = 1'b0;
      #1;
      compare(1'b0, 8'd22, 1'b0, "R5 async reset");
      m_drv = 4'h0; m_ovr = 2'b00;
      @(negedge clk); rst_n = 1'b1;
      sweep(2'd3, "R5 drv cleared");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule